// File: doc/BRIEF.md
# Operand Barrel Shifter with Carry

This block forms the second operand of an integer ALU from a data word, together with the shifter carry that flag logic may later take as the new carry flag. It is purely combinational. It offers five operations: shift left with zero fill, shift right with zero fill, shift right with sign fill, rotate right, and a one-bit rotate right that passes through the carry flag. The shift count comes either from a 5-bit immediate field or from the low byte of a register. The carry result depends on where the count came from, because the two sources treat a count of zero and counts of 32 or more differently.

A second operand mode builds a constant instead of a shifted value. An 8-bit value is zero-extended and then rotated right by twice a 4-bit rotate field. In this mode the shift controls and the data word play no part. The ALU, the flag write-back and the instruction decode that drive the selects are outside this block.

The block has no clock and no reset. The outputs follow the inputs within the same cycle.

Top module: `operand_shifter`

## Requirements
- R1: With kind_i = 2'b00 (shift left) and a count n from 1 to 31, result_o is data_i shifted left by n with zeros entering at the bottom, and carry_o is data_i[32-n].
- R2: With kind_i = 2'b01 (logical shift right) and a count n from 1 to 31, result_o is data_i shifted right by n with zeros entering at the top, and carry_o is data_i[n-1].
- R3: With kind_i = 2'b10 (arithmetic shift right) and a count n from 1 to 31, the vacated top bits are copies of data_i[31], and carry_o is data_i[n-1].
- R4: With kind_i = 2'b11 (rotate right) and an effective count n from 1 to 31, bits leaving bit 0 re-enter at bit 31, and carry_o equals result_o[31].
- R5: With an immediate count (amt_sel_i = 0), rotate right by 0 performs the one-bit rotate through carry: result_o = {carry_i, data_i[31:1]} and carry_o = data_i[0].
- R6: With an immediate count, shift left by 0 passes data_i through with carry_o = carry_i. Logical shift right by 0 and arithmetic shift right by 0 each act as a shift by 32.
- R7: With a register count (amt_sel_i = 1) whose low byte reg_amt_i is 0, every kind passes data_i through unchanged with carry_o = carry_i.
- R8: With a register count of exactly 32, shift left gives 0 with carry_o = data_i[0], and logical shift right gives 0 with carry_o = data_i[31].
- R9: With a register count above 32, shift left and logical shift right both give 0 with carry_o = 0.
- R10: Arithmetic shift right by 32 or more sets every result bit to data_i[31], and carry_o = data_i[31].
- R11: A register-sourced rotate uses the count modulo 32. A nonzero multiple of 32 returns data_i unchanged with carry_o = data_i[31].
- R12: With rotimm_en_i = 1, result_o is imm8_i zero-extended and rotated right by 2*rot_i. carry_o is carry_i when rot_i = 0 and result_o[31] otherwise. data_i and the shift controls have no effect in this mode.
- R13: amt_sel_i = 0 takes the count from imm_amt_i and amt_sel_i = 1 takes it from reg_amt_i. The count source that is not selected has no effect on either output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | 32 | Data word to be shifted |
| carry_i | input | 1 | Current carry flag |
| kind_i | input | 2 | Shift kind: 00 left, 01 logical right, 10 arithmetic right, 11 rotate right |
| amt_sel_i | input | 1 | Count source: 0 immediate, 1 register |
| imm_amt_i | input | 5 | Immediate shift count |
| reg_amt_i | input | 8 | Low byte of the count register |
| rotimm_en_i | input | 1 | Selects the rotated-constant operand mode |
| imm8_i | input | 8 | Constant byte for the rotated-constant mode |
| rot_i | input | 4 | Rotate field; the rotation is twice this value |
| result_o | output | 32 | Operand for the ALU |
| carry_o | output | 1 | Shifter carry-out |

## Verification
The bench builds the block with its default widths: a 32-bit word, an 8-bit register count and a 4-bit rotate field. With these widths a register count can reach 255. That range covers counts of exactly 32, just above 32, far above 32, and nonzero multiples of 32 for the rotate, as well as the zero-count special meanings of the 5-bit immediate. Expected values come from a bit-by-bit stepping model in the bench.

// File: rtl/operand_shifter_pkg.sv
package operand_shifter_pkg;

    typedef enum logic [1:0] {
        KIND_LSL = 2'd0,
        KIND_LSR = 2'd1,
        KIND_ASR = 2'd2,
        KIND_ROR = 2'd3
    } shift_kind_e;

    typedef enum logic [2:0] {
        OP_PASS,
        OP_LSL,
        OP_LSR,
        OP_ASR,
        OP_ROR,
        OP_RRX
    } shift_op_e;

    typedef enum logic [1:0] {
        CLS_MID,
        CLS_FULL,
        CLS_OVER
    } amt_class_e;

    function automatic shift_op_e kind_to_op(input shift_kind_e k);
        shift_op_e o;
        unique case (k)
            KIND_LSL: o = OP_LSL;
            KIND_LSR: o = OP_LSR;
            KIND_ASR: o = OP_ASR;
            KIND_ROR: o = OP_ROR;
            default:  o = OP_PASS;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/shift_amount_decode.sv
module shift_amount_decode
    import operand_shifter_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int REG_AMT_W = 8,
    localparam int SH_W     = $clog2(DATA_W)
) (
    input  shift_kind_e           kind,
    input  logic                  amt_sel,
    input  logic [SH_W-1:0]       imm_amt,
    input  logic [REG_AMT_W-1:0]  reg_amt,
    output shift_op_e             op,
    output amt_class_e            cls,
    output logic [SH_W-1:0]       amt
);

    localparam logic [REG_AMT_W-1:0] FULL_AMT = REG_AMT_W'(DATA_W);

    always_comb begin
        op  = OP_PASS;
        cls = CLS_MID;
        amt = '0;
        if (!amt_sel) begin
            amt = imm_amt;
            if (imm_amt == '0) begin
                unique case (kind)
                    KIND_LSL: op = OP_PASS;
                    KIND_LSR: begin op = OP_LSR; cls = CLS_FULL; end
                    KIND_ASR: begin op = OP_ASR; cls = CLS_FULL; end
                    KIND_ROR: op = OP_RRX;
                    default:  op = OP_PASS;
                endcase
            end else begin
                op = kind_to_op(kind);
            end
        end else begin
            amt = reg_amt[SH_W-1:0];
            if (reg_amt == '0) begin
                op = OP_PASS;
            end else if (kind == KIND_ROR) begin
                op  = OP_ROR;
                cls = (reg_amt[SH_W-1:0] == '0) ? CLS_FULL : CLS_MID;
            end else begin
                op = kind_to_op(kind);
                if (reg_amt < FULL_AMT)
                    cls = CLS_MID;
                else if (reg_amt == FULL_AMT)
                    cls = CLS_FULL;
                else
                    cls = CLS_OVER;
            end
        end

        // R5
        if (!amt_sel && imm_amt == '0 && kind == KIND_ROR)
            imm_ror_zero_chk: assert (op == OP_RRX)
                else $error("imm rotate by zero not mapped to rrx");
        // R6
        if (!amt_sel && imm_amt == '0 && (kind == KIND_LSR || kind == KIND_ASR))
            imm_right_zero_chk: assert (cls == CLS_FULL && op != OP_PASS)
                else $error("imm right shift by zero not full width");
        // R7
        if (amt_sel && reg_amt == '0)
            reg_zero_pass_chk: assert (op == OP_PASS)
                else $error("register zero count not pass");
        // R11
        if (op == OP_ROR)
            ror_never_over_chk: assert (cls != CLS_OVER)
                else $error("rotate classed above width");
    end

endmodule

// File: rtl/shift_core.sv
module shift_core
    import operand_shifter_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int SH_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] val,
    input  logic              carry_in,
    input  shift_op_e         op,
    input  amt_class_e        cls,
    input  logic [SH_W-1:0]   amt,
    output logic [DATA_W-1:0] result,
    output logic              carry_out
);

    logic [DATA_W:0]        lsl_ext;
    logic [DATA_W:0]        lsr_ext;
    logic signed [DATA_W:0] asr_ext;
    logic [SH_W-1:0]        amt_neg;
    logic [DATA_W-1:0]      ror_val;
    logic [DATA_W-1:0]      sign_fill;

    assign amt_neg   = ~amt + 1'b1;
    assign lsl_ext   = {1'b0, val} << amt;
    assign lsr_ext   = {val, 1'b0} >> amt;
    assign asr_ext   = $signed({val, 1'b0}) >>> amt;
    assign ror_val   = (val >> amt) | (val << amt_neg);
    assign sign_fill = {DATA_W{val[DATA_W-1]}};

    always_comb begin
        result    = val;
        carry_out = carry_in;
        unique case (op)
            OP_PASS: begin
                result    = val;
                carry_out = carry_in;
            end
            OP_RRX: begin
                result    = {carry_in, val[DATA_W-1:1]};
                carry_out = val[0];
            end
            OP_LSL: begin
                unique case (cls)
                    CLS_MID:  begin result = lsl_ext[DATA_W-1:0]; carry_out = lsl_ext[DATA_W]; end
                    CLS_FULL: begin result = '0; carry_out = val[0]; end
                    default:  begin result = '0; carry_out = 1'b0; end
                endcase
            end
            OP_LSR: begin
                unique case (cls)
                    CLS_MID:  begin result = lsr_ext[DATA_W:1]; carry_out = lsr_ext[0]; end
                    CLS_FULL: begin result = '0; carry_out = val[DATA_W-1]; end
                    default:  begin result = '0; carry_out = 1'b0; end
                endcase
            end
            OP_ASR: begin
                if (cls == CLS_MID) begin
                    result    = asr_ext[DATA_W:1];
                    carry_out = asr_ext[0];
                end else begin
                    result    = sign_fill;
                    carry_out = val[DATA_W-1];
                end
            end
            OP_ROR: begin
                if (cls == CLS_MID) begin
                    result    = ror_val;
                    carry_out = ror_val[DATA_W-1];
                end else begin
                    result    = val;
                    carry_out = val[DATA_W-1];
                end
            end
            default: begin
                result    = val;
                carry_out = carry_in;
            end
        endcase

        // R1
        if (op == OP_LSL && cls == CLS_MID)
            lsl_low_zero_chk: assert (result[0] == 1'b0)
                else $error("left shift did not zero-fill");
        // R2
        if (op == OP_LSR && cls == CLS_MID)
            lsr_top_zero_chk: assert (result[DATA_W-1] == 1'b0)
                else $error("logical right shift did not zero-fill");
        // R3
        if (op == OP_ASR)
            asr_sign_keep_chk: assert (result[DATA_W-1] == val[DATA_W-1])
                else $error("arithmetic shift lost sign");
        // R4
        if (op == OP_ROR)
            ror_popcount_chk: assert ($countones(result) == $countones(val))
                else $error("rotate changed bit count");
        // R9
        if ((op == OP_LSL || op == OP_LSR) && cls == CLS_OVER)
            over_zero_chk: assert (result == '0 && !carry_out)
                else $error("over-width shift not zero");
        // R10
        if (op == OP_ASR && cls != CLS_MID)
            asr_fill_chk: assert (($countones(result) == 0 || $countones(result) == DATA_W)
                                  && carry_out == val[DATA_W-1])
                else $error("arithmetic full shift not sign filled");
    end

endmodule

// File: rtl/rot_const_gen.sv
module rot_const_gen #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 8,
    parameter int ROT_W  = 4,
    localparam int SH_W  = $clog2(DATA_W)
) (
    input  logic [IMM_W-1:0]  imm8,
    input  logic [ROT_W-1:0]  rot,
    input  logic              carry_in,
    output logic [DATA_W-1:0] result,
    output logic              carry_out
);

    logic [DATA_W-1:0] base;
    logic [SH_W-1:0]   ramt;
    logic [SH_W-1:0]   ramt_neg;

    assign base     = DATA_W'(imm8);
    assign ramt     = SH_W'({rot, 1'b0});
    assign ramt_neg = ~ramt + 1'b1;

    always_comb begin
        result    = (base >> ramt) | (base << ramt_neg);
        carry_out = (rot == '0) ? carry_in : result[DATA_W-1];

        // R12
        rot_popcount_chk: assert ($countones(result) == $countones(imm8))
            else $error("constant rotate changed bit count");
    end

endmodule

// File: rtl/operand_shifter.sv
module operand_shifter
    import operand_shifter_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int REG_AMT_W = 8,
    parameter int IMM_W     = 8,
    parameter int ROT_W     = 4,
    localparam int SH_W     = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0]    data_i,
    input  logic                 carry_i,
    input  logic [1:0]           kind_i,
    input  logic                 amt_sel_i,
    input  logic [SH_W-1:0]      imm_amt_i,
    input  logic [REG_AMT_W-1:0] reg_amt_i,
    input  logic                 rotimm_en_i,
    input  logic [IMM_W-1:0]     imm8_i,
    input  logic [ROT_W-1:0]     rot_i,
    output logic [DATA_W-1:0]    result_o,
    output logic                 carry_o
);

    shift_op_e         dec_op;
    amt_class_e        dec_cls;
    logic [SH_W-1:0]   dec_amt;
    logic [DATA_W-1:0] sh_result;
    logic              sh_carry;
    logic [DATA_W-1:0] rc_result;
    logic              rc_carry;

    shift_amount_decode #(
        .DATA_W    (DATA_W),
        .REG_AMT_W (REG_AMT_W)
    ) u_decode (
        .kind    (shift_kind_e'(kind_i)),
        .amt_sel (amt_sel_i),
        .imm_amt (imm_amt_i),
        .reg_amt (reg_amt_i),
        .op      (dec_op),
        .cls     (dec_cls),
        .amt     (dec_amt)
    );

    shift_core #(
        .DATA_W (DATA_W)
    ) u_core (
        .val       (data_i),
        .carry_in  (carry_i),
        .op        (dec_op),
        .cls       (dec_cls),
        .amt       (dec_amt),
        .result    (sh_result),
        .carry_out (sh_carry)
    );

    rot_const_gen #(
        .DATA_W (DATA_W),
        .IMM_W  (IMM_W),
        .ROT_W  (ROT_W)
    ) u_rotc (
        .imm8      (imm8_i),
        .rot       (rot_i),
        .carry_in  (carry_i),
        .result    (rc_result),
        .carry_out (rc_carry)
    );

    always_comb begin
        if (rotimm_en_i) begin
            result_o = rc_result;
            carry_o  = rc_carry;
        end else begin
            result_o = sh_result;
            carry_o  = sh_carry;
        end
    end

endmodule

// File: tb/operand_shifter_test.sv
module operand_shifter_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic [31:0] data_i = '0;
    logic        carry_i = 1'b0;
    logic [1:0]  kind_i = '0;
    logic        amt_sel_i = 1'b0;
    logic [4:0]  imm_amt_i = '0;
    logic [7:0]  reg_amt_i = '0;
    logic        rotimm_en_i = 1'b0;
    logic [7:0]  imm8_i = '0;
    logic [3:0]  rot_i = '0;
    logic [31:0] result_o;
    logic        carry_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    operand_shifter uut (
        .data_i      (data_i),
        .carry_i     (carry_i),
        .kind_i      (kind_i),
        .amt_sel_i   (amt_sel_i),
        .imm_amt_i   (imm_amt_i),
        .reg_amt_i   (reg_amt_i),
        .rotimm_en_i (rotimm_en_i),
        .imm8_i      (imm8_i),
        .rot_i       (rot_i),
        .result_o    (result_o),
        .carry_o     (carry_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Stepping model: one bit per step, written from the requirements.
    function automatic logic [32:0] model(
        input logic [31:0] d, input logic c, input logic [1:0] k,
        input logic sel, input logic [4:0] ia, input logic [7:0] ra,
        input logic re, input logic [7:0] i8, input logic [3:0] rt);
        logic [31:0] v;
        logic        co;
        int          n;
        co = c;
        if (re) begin
            v = {24'b0, i8};
            for (int i = 0; i < 2*int'(rt); i++) v = {v[0], v[31:1]};
            co = (rt == 0) ? c : v[31];
            return {co, v};
        end
        v = d;
        if (sel) n = int'(ra);
        else begin
            n = int'(ia);
            if (ia == 0) begin
                if (k == 2'd1 || k == 2'd2) n = 32;
                else if (k == 2'd3) return {d[0], c, d[31:1]};
            end
        end
        for (int i = 0; i < n; i++) begin
            case (k)
                2'd0: begin co = v[31]; v = v << 1; end
                2'd1: begin co = v[0];  v = v >> 1; end
                2'd2: begin co = v[0];  v = {v[31], v[31:1]}; end
                default: begin co = v[0]; v = {v[0], v[31:1]}; end
            endcase
        end
        return {co, v};
    endfunction

    task automatic check(input string tag, input logic [31:0] er, input logic ec);
        n_tests++;
        if (result_o !== er || carry_o !== ec) begin
            n_fail++;
            $display("FAIL %s: got res=%h c=%b, expected res=%h c=%b",
                     tag, result_o, carry_o, er, ec);
        end
    endtask

    task automatic apply_shift(input string tag, input logic [31:0] d, input logic c,
                               input logic [1:0] k, input logic sel,
                               input logic [4:0] ia, input logic [7:0] ra);
        logic [32:0] e;
        data_i = d; carry_i = c; kind_i = k; amt_sel_i = sel;
        imm_amt_i = ia; reg_amt_i = ra; rotimm_en_i = 1'b0;
        #1;
        e = model(d, c, k, sel, ia, ra, 1'b0, 8'h0, 4'h0);
        check(tag, e[31:0], e[32]);
    endtask

    task automatic t_reset_state;
        #1;
        check("R7 idle zero inputs", 32'h0, 1'b0);
    endtask

    task automatic t_imm_shifts;
        logic [31:0] pats [3] = '{32'h8000_0001, 32'hA5C3_0F96, 32'h7FFF_FFFE};
        int amts [4] = '{1, 4, 17, 31};
        foreach (pats[p]) foreach (amts[a]) begin
            apply_shift("R1 lsl imm", pats[p], 1'b0, 2'd0, 1'b0, 5'(amts[a]), 8'd0);
            apply_shift("R2 lsr imm", pats[p], 1'b1, 2'd1, 1'b0, 5'(amts[a]), 8'd0);
            apply_shift("R3 asr imm", pats[p], 1'b0, 2'd2, 1'b0, 5'(amts[a]), 8'd0);
            apply_shift("R4 ror imm", pats[p], 1'b0, 2'd3, 1'b0, 5'(amts[a]), 8'd0);
        end
        apply_shift("R1 lsl 4 fixed", 32'h1234_5678, 1'b0, 2'd0, 1'b0, 5'd4, 8'd0);
        check("R1 lsl 4 literal", 32'h2345_6780, 1'b1);
        apply_shift("R3 asr 4 fixed", 32'h8000_00F0, 1'b0, 2'd2, 1'b0, 5'd4, 8'd0);
        check("R3 asr 4 literal", 32'hF800_000F, 1'b0);
    endtask

    task automatic t_imm_zero;
        apply_shift("R6 lsl #0 pass", 32'hDEAD_BEEF, 1'b1, 2'd0, 1'b0, 5'd0, 8'd0);
        check("R6 lsl #0 literal", 32'hDEAD_BEEF, 1'b1);
        apply_shift("R6 lsr #0 as 32", 32'h8000_0000, 1'b0, 2'd1, 1'b0, 5'd0, 8'd0);
        check("R6 lsr #0 literal", 32'h0, 1'b1);
        apply_shift("R6 asr #0 as 32", 32'h8000_0000, 1'b0, 2'd2, 1'b0, 5'd0, 8'd0);
        check("R6 asr #0 literal", 32'hFFFF_FFFF, 1'b1);
    endtask

    task automatic t_rrx;
        apply_shift("R5 rrx c=1", 32'h0000_0003, 1'b1, 2'd3, 1'b0, 5'd0, 8'd0);
        check("R5 rrx c=1 literal", 32'h8000_0001, 1'b1);
        apply_shift("R5 rrx c=0", 32'h8000_0002, 1'b0, 2'd3, 1'b0, 5'd0, 8'd0);
        check("R5 rrx c=0 literal", 32'h4000_0001, 1'b0);
    endtask

    task automatic t_reg_zero;
        for (int k = 0; k < 4; k++) begin
            apply_shift("R7 reg zero", 32'hC001_D00D, 1'b1, 2'(k), 1'b1, 5'd9, 8'd0);
            check("R7 reg zero literal", 32'hC001_D00D, 1'b1);
        end
    endtask

    task automatic t_reg_32;
        apply_shift("R8 lsl reg 32", 32'h0000_0001, 1'b0, 2'd0, 1'b1, 5'd0, 8'd32);
        check("R8 lsl reg 32 literal", 32'h0, 1'b1);
        apply_shift("R8 lsr reg 32", 32'h8000_0000, 1'b0, 2'd1, 1'b1, 5'd0, 8'd32);
        check("R8 lsr reg 32 literal", 32'h0, 1'b1);
        apply_shift("R2 lsr reg 31", 32'hF000_0000, 1'b0, 2'd1, 1'b1, 5'd0, 8'd31);
    endtask

    task automatic t_reg_over;
        int amts [3] = '{33, 100, 255};
        foreach (amts[a]) begin
            apply_shift("R9 lsl reg over", 32'hFFFF_FFFF, 1'b1, 2'd0, 1'b1, 5'd0, 8'(amts[a]));
            check("R9 lsl over literal", 32'h0, 1'b0);
            apply_shift("R9 lsr reg over", 32'hFFFF_FFFF, 1'b1, 2'd1, 1'b1, 5'd0, 8'(amts[a]));
            check("R9 lsr over literal", 32'h0, 1'b0);
        end
    endtask

    task automatic t_asr_big;
        int amts [3] = '{32, 40, 255};
        foreach (amts[a]) begin
            apply_shift("R10 asr neg", 32'h8123_4567, 1'b0, 2'd2, 1'b1, 5'd0, 8'(amts[a]));
            check("R10 asr neg literal", 32'hFFFF_FFFF, 1'b1);
            apply_shift("R10 asr pos", 32'h7123_4567, 1'b1, 2'd2, 1'b1, 5'd0, 8'(amts[a]));
            check("R10 asr pos literal", 32'h0, 1'b0);
        end
    endtask

    task automatic t_ror_reg;
        apply_shift("R11 ror reg 32", 32'h8765_4321, 1'b0, 2'd3, 1'b1, 5'd0, 8'd32);
        check("R11 ror 32 literal", 32'h8765_4321, 1'b1);
        apply_shift("R11 ror reg 64", 32'h1765_4321, 1'b1, 2'd3, 1'b1, 5'd0, 8'd64);
        check("R11 ror 64 literal", 32'h1765_4321, 1'b0);
        apply_shift("R11 ror reg 36", 32'h0000_00F8, 1'b0, 2'd3, 1'b1, 5'd0, 8'd36);
        check("R11 ror 36 literal", 32'h8000_000F, 1'b1);
        apply_shift("R11 ror reg 200", 32'hA5C3_0F96, 1'b0, 2'd3, 1'b1, 5'd0, 8'd200);
    endtask

    task automatic t_rotimm;
        logic [32:0] e;
        int rots [4] = '{0, 1, 4, 15};
        foreach (rots[r]) for (int cin = 0; cin < 2; cin++) begin
            data_i = 32'hFFFF_FFFF; kind_i = 2'd1; amt_sel_i = 1'b0; imm_amt_i = 5'd3;
            carry_i = 1'(cin); rotimm_en_i = 1'b1; imm8_i = 8'hC3; rot_i = 4'(rots[r]);
            #1;
            e = model(32'h0, 1'(cin), 2'd0, 1'b0, 5'd0, 8'd0, 1'b1, 8'hC3, 4'(rots[r]));
            check("R12 rotated constant", e[31:0], e[32]);
        end
        rot_i = 4'd4; imm8_i = 8'hFF; carry_i = 1'b0; data_i = 32'h0; kind_i = 2'd0;
        #1;
        check("R12 rot 4 literal", 32'hFF00_0000, 1'b1);
        rotimm_en_i = 1'b0;
    endtask

    task automatic t_src_ignore;
        for (int v = 0; v < 3; v++) begin
            apply_shift("R13 imm ignored", 32'h1357_9BDF, 1'b0, 2'd1, 1'b1, 5'(v*11 + 1), 8'd5);
            check("R13 imm ignored literal", 32'h009A_BCDE, 1'b1);
            apply_shift("R13 reg ignored", 32'h1357_9BDF, 1'b0, 2'd1, 1'b0, 5'd5, 8'(v*90));
            check("R13 reg ignored literal", 32'h009A_BCDE, 1'b1);
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset_state();
        t_imm_shifts();
        t_imm_zero();
        t_rrx();
        t_reg_zero();
        t_reg_32();
        t_reg_over();
        t_asr_big();
        t_ror_reg();
        t_rotimm();
        t_src_ignore();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule